// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus-write path of a NOR-style flash controller. Each accepted write carries a word address and a data word. The block follows the multi-write unlock sequences that guard every flash command and issues a single-cycle pulse when a sequence completes. A completed word program reports its target address and data. A completed block erase reports the block index. The other commands (read/reset, identification-mode entry, chip erase and streamed-program start) report only the pulse.

The block also tracks whether the part is in normal read mode or in identification mode. While identification mode is active, a two-bit read selector returns the maker and device identity words. The program/erase engine drives a busy input. While busy is high, every write is dropped. A program-voltage flag decides whether program and erase commands may start. Read/reset and identification entry work whatever the flag says.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Out of synchronous reset, the decoder is in read mode (`autosel_mode`=0), every pulse output is 0, and `id_data` is 0000h.
- R2: Command matching uses only `wr_addr[10:0]` and `wr_data[7:0]`. The upper address bits and upper data bits are ignored. For example, a write of data xxAAh to address xxx555h counts as a first unlock write.
- R3: A write whose low data byte is F0h causes a read/reset. It may come as a single write to any address, or after any partial unlock or erase prefix (AAh@555h, 55h@2AAh, ...). It raises `reset_pulse` one cycle later and returns the decoder to read mode. The one exception is the data slot of a word program.
- R4: The sequence AAh@555h, 55h@2AAh, 90h@555h raises `autosel_pulse` and sets `autosel_mode`. The mode stays set through any write whose low data byte is not F0h. A write whose low data byte is F0h clears the mode and raises `reset_pulse`.
- R5: The sequence AAh@555h, 55h@2AAh, A0h@555h, followed by a fourth write, raises `prog_pulse` with `prog_addr` and `prog_data` equal to the fourth write's full address and data. The fourth write is taken as data whatever its value.
- R6: The sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, followed by 30h at any address, raises `erase_blk_pulse` with `blk_idx` = `wr_addr[21:17]`.
- R7: The same five-write erase prefix, followed by 10h@555h, raises `erase_chip_pulse`.
- R8: The sequence AAh@555h, 55h@2AAh, 20h@555h raises `mwp_start_pulse`.
- R9: Any write that does not continue the current sequence returns the decoder to read mode without a pulse. A new sequence must then start again from AAh@555h.
- R10: If `vpp_ok` is 0 on the write that would launch a word program, block erase, chip erase or streamed program, no pulse is raised and the decoder returns to read mode.
- R11: While `busy` is 1, writes are ignored, including F0h. No pulse is raised, and the sequence state and the mode are held.
- R12: `id_data` follows `rd_sel` with one cycle of latency. In identification mode, `rd_sel`=00 gives 0020h, `rd_sel`=01 gives 88AFh, and any other value gives 0000h. Outside identification mode, `id_data` is 0000h.
- R13: At most one pulse output is high in any cycle. Each pulse lasts one cycle and appears in the cycle after the write that caused it. A cycle without an accepted write produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 22 | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| vpp_ok | input | 1 | Program voltage in range; permits program/erase launch |
| busy | input | 1 | Program/erase engine running; writes are dropped |
| rd_sel | input | 2 | Low address bits of an identification read |
| reset_pulse | output | 1 | Read/reset accepted |
| autosel_pulse | output | 1 | Identification mode entered |
| prog_pulse | output | 1 | Word program launched |
| prog_addr | output | 22 | Address of the launched word program |
| prog_data | output | 16 | Data of the launched word program |
| erase_blk_pulse | output | 1 | Block erase launched |
| blk_idx | output | 5 | Block to erase |
| erase_chip_pulse | output | 1 | Chip erase launched |
| mwp_start_pulse | output | 1 | Streamed multi-word program launched |
| autosel_mode | output | 1 | Identification mode active |
| id_data | output | 16 | Identity word selected by rd_sel |

## Verification
The bound checker watches several rules on every cycle. It checks that at most one pulse is high at a time, that a cycle with no write, or with busy high, yields no pulse and leaves the mode unchanged, and that a write with the voltage flag low never launches a program or erase. It also checks that identification mode survives every write except F0h, and that `id_data` stays zero outside that mode. Only the bench's write sequences can show the rest: that each command is recognised in its exact order, that a broken sequence does not leave the decoder halfway, that high bits are ignored, and that the launch address, data and block index are captured correctly.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_PGM,
    ST_ER1,
    ST_ER2,
    ST_ER3,
    ST_ASEL
  } seq_state_t;

  // Classification of one bus write, low bits only
  typedef struct packed {
    logic unl1;  // AA at 555
    logic unl2;  // 55 at 2AA
    logic f0;    // F0 anywhere
    logic as90;  // 90 at 555
    logic pga0;  // A0 at 555
    logic er80;  // 80 at 555
    logic ch10;  // 10 at 555
    logic bk30;  // 30 anywhere
    logic mw20;  // 20 at 555
  } wr_class_t;

endpackage

// File: rtl/fcd_match.sv
module fcd_match #(
  parameter int CMP_AW = 11,
  parameter int CMP_DW = 8
) (
  input  logic [CMP_AW-1:0]  a_lo,
  input  logic [CMP_DW-1:0]  d_lo,
  output fcd_pkg::wr_class_t cls
);
  localparam logic [CMP_AW-1:0] KEY_A1 = CMP_AW'(12'h555);
  localparam logic [CMP_AW-1:0] KEY_A2 = CMP_AW'(12'h2AA);
  localparam logic [CMP_DW-1:0] D_AA   = CMP_DW'(8'hAA);
  localparam logic [CMP_DW-1:0] D_55   = CMP_DW'(8'h55);
  localparam logic [CMP_DW-1:0] D_F0   = CMP_DW'(8'hF0);
  localparam logic [CMP_DW-1:0] D_90   = CMP_DW'(8'h90);
  localparam logic [CMP_DW-1:0] D_A0   = CMP_DW'(8'hA0);
  localparam logic [CMP_DW-1:0] D_80   = CMP_DW'(8'h80);
  localparam logic [CMP_DW-1:0] D_10   = CMP_DW'(8'h10);
  localparam logic [CMP_DW-1:0] D_30   = CMP_DW'(8'h30);
  localparam logic [CMP_DW-1:0] D_20   = CMP_DW'(8'h20);

  logic at_k1, at_k2;

  always_comb begin
    at_k1    = (a_lo == KEY_A1);
    at_k2    = (a_lo == KEY_A2);
    cls.unl1 = at_k1 && (d_lo == D_AA);
    cls.unl2 = at_k2 && (d_lo == D_55);
    cls.f0   = (d_lo == D_F0);
    cls.as90 = at_k1 && (d_lo == D_90);
    cls.pga0 = at_k1 && (d_lo == D_A0);
    cls.er80 = at_k1 && (d_lo == D_80);
    cls.ch10 = at_k1 && (d_lo == D_10);
    cls.bk30 = (d_lo == D_30);
    cls.mw20 = at_k1 && (d_lo == D_20);
  end

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               busy,
  input  logic               vpp_ok,
  input  fcd_pkg::wr_class_t cls,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               reset_pulse,
  output logic               autosel_pulse,
  output logic               prog_pulse,
  output logic [ADDR_W-1:0]  prog_addr,
  output logic [DATA_W-1:0]  prog_data,
  output logic               erase_blk_pulse,
  output logic [BLK_W-1:0]   blk_idx,
  output logic               erase_chip_pulse,
  output logic               mwp_start_pulse,
  output logic               autosel_mode
);
  import fcd_pkg::*;

  seq_state_t st, st_nxt;
  logic accept;
  logic n_rst, n_asel, n_prog, n_blk, n_chip, n_mwp;

  always_comb begin
    accept = wr_en && !busy;
    st_nxt = st;
    n_rst  = 1'b0;
    n_asel = 1'b0;
    n_prog = 1'b0;
    n_blk  = 1'b0;
    n_chip = 1'b0;
    n_mwp  = 1'b0;
    if (accept) begin
      if (st == ST_ASEL) begin
        if (cls.f0) begin
          st_nxt = ST_READ;
          n_rst  = 1'b1;
        end
      end else if (cls.f0 && st != ST_PGM) begin
        st_nxt = ST_READ;
        n_rst  = 1'b1;
      end else begin
        st_nxt = ST_READ;
        unique case (st)
          ST_READ: if (cls.unl1) st_nxt = ST_UNL1;
          ST_UNL1: if (cls.unl2) st_nxt = ST_UNL2;
          ST_UNL2: begin
            if (cls.as90) begin
              st_nxt = ST_ASEL;
              n_asel = 1'b1;
            end else if (cls.pga0) begin
              st_nxt = ST_PGM;
            end else if (cls.er80) begin
              st_nxt = ST_ER1;
            end else if (cls.mw20) begin
              n_mwp = vpp_ok;
            end
          end
          ST_PGM:  n_prog = vpp_ok;
          ST_ER1:  if (cls.unl1) st_nxt = ST_ER2;
          ST_ER2:  if (cls.unl2) st_nxt = ST_ER3;
          ST_ER3: begin
            if (cls.ch10)      n_chip = vpp_ok;
            else if (cls.bk30) n_blk  = vpp_ok;
          end
          default: st_nxt = ST_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st               <= ST_READ;
      reset_pulse      <= 1'b0;
      autosel_pulse    <= 1'b0;
      prog_pulse       <= 1'b0;
      erase_blk_pulse  <= 1'b0;
      erase_chip_pulse <= 1'b0;
      mwp_start_pulse  <= 1'b0;
      prog_addr        <= '0;
      prog_data        <= '0;
      blk_idx          <= '0;
    end else begin
      st               <= st_nxt;
      reset_pulse      <= n_rst;
      autosel_pulse    <= n_asel;
      prog_pulse       <= n_prog;
      erase_blk_pulse  <= n_blk;
      erase_chip_pulse <= n_chip;
      mwp_start_pulse  <= n_mwp;
      if (n_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (n_blk) blk_idx <= wr_addr[ADDR_W-1 -: BLK_W];
    end
  end

  assign autosel_mode = (st == ST_ASEL);

endmodule

// File: rtl/fcd_id.sv
module fcd_id #(
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0020,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h88AF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              asel,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] id_data
);
  always_ff @(posedge clk) begin
    if (rst || !asel) begin
      id_data <= '0;
    end else begin
      unique case (rd_sel)
        2'b00:   id_data <= MFR_CODE;
        2'b01:   id_data <= DEV_CODE;
        default: id_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int CMP_AW = 11,
  parameter int CMP_DW = 8,
  parameter int BLK_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vpp_ok,
  input  logic              busy,
  input  logic [1:0]        rd_sel,
  output logic              reset_pulse,
  output logic              autosel_pulse,
  output logic              prog_pulse,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_blk_pulse,
  output logic [BLK_W-1:0]  blk_idx,
  output logic              erase_chip_pulse,
  output logic              mwp_start_pulse,
  output logic              autosel_mode,
  output logic [DATA_W-1:0] id_data
);
  fcd_pkg::wr_class_t cls;

  fcd_match #(.CMP_AW(CMP_AW), .CMP_DW(CMP_DW)) u_match (
    .a_lo (wr_addr[CMP_AW-1:0]),
    .d_lo (wr_data[CMP_DW-1:0]),
    .cls  (cls)
  );

  fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_seq (
    .clk              (clk),
    .rst              (rst),
    .wr_en            (wr_en),
    .busy             (busy),
    .vpp_ok           (vpp_ok),
    .cls              (cls),
    .wr_addr          (wr_addr),
    .wr_data          (wr_data),
    .reset_pulse      (reset_pulse),
    .autosel_pulse    (autosel_pulse),
    .prog_pulse       (prog_pulse),
    .prog_addr        (prog_addr),
    .prog_data        (prog_data),
    .erase_blk_pulse  (erase_blk_pulse),
    .blk_idx          (blk_idx),
    .erase_chip_pulse (erase_chip_pulse),
    .mwp_start_pulse  (mwp_start_pulse),
    .autosel_mode     (autosel_mode)
  );

  fcd_id #(.DATA_W(DATA_W)) u_id (
    .clk     (clk),
    .rst     (rst),
    .asel    (autosel_mode),
    .rd_sel  (rd_sel),
    .id_data (id_data)
  );

endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
  parameter int DATA_W = 16,
  parameter int CMP_DW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              vpp_ok,
  input logic              busy,
  input logic              reset_pulse,
  input logic              autosel_pulse,
  input logic              prog_pulse,
  input logic              erase_blk_pulse,
  input logic              erase_chip_pulse,
  input logic              mwp_start_pulse,
  input logic              autosel_mode,
  input logic [DATA_W-1:0] id_data
);
  logic [5:0] pv;
  logic       f0_acc;
  assign pv = {reset_pulse, autosel_pulse, prog_pulse,
               erase_blk_pulse, erase_chip_pulse, mwp_start_pulse};
  assign f0_acc = wr_en && !busy && (wr_data[CMP_DW-1:0] == CMP_DW'(8'hF0));

  // R13
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(pv));
  // R13
  quiet_idle_chk: assert property (@(posedge clk) disable iff (rst) !wr_en |=> (pv == 6'b0));
  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> (pv == 6'b0 && $stable(autosel_mode)));
  // R10
  vpp_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !vpp_ok) |=> !(prog_pulse || erase_blk_pulse || erase_chip_pulse || mwp_start_pulse));
  // R4
  asel_enter_chk: assert property (@(posedge clk) disable iff (rst) autosel_pulse |-> autosel_mode);
  // R4
  asel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (autosel_mode && !f0_acc) |=> autosel_mode);
  // R12
  id_zero_chk: assert property (@(posedge clk) disable iff (rst) !autosel_mode |=> (id_data == '0));

endmodule

bind flash_cmd_decoder fcd_chk #(.DATA_W(DATA_W), .CMP_DW(CMP_DW)) u_fcd_chk (
  .clk              (clk),
  .rst              (rst),
  .wr_en            (wr_en),
  .wr_data          (wr_data),
  .vpp_ok           (vpp_ok),
  .busy             (busy),
  .reset_pulse      (reset_pulse),
  .autosel_pulse    (autosel_pulse),
  .prog_pulse       (prog_pulse),
  .erase_blk_pulse  (erase_blk_pulse),
  .erase_chip_pulse (erase_chip_pulse),
  .mwp_start_pulse  (mwp_start_pulse),
  .autosel_mode     (autosel_mode),
  .id_data          (id_data)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [21:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        vpp_ok = 1'b1;
  logic        busy = 1'b0;
  logic [1:0]  rd_sel = 2'b00;
  logic        reset_pulse, autosel_pulse, prog_pulse, erase_blk_pulse;
  logic        erase_chip_pulse, mwp_start_pulse, autosel_mode;
  logic [21:0] prog_addr;
  logic [15:0] prog_data, id_data;
  logic [4:0]  blk_idx;

  int n_chk = 0;
  int n_err = 0;
  logic [5:0] got_p;
  logic       got_m;

  always #4 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_ok(vpp_ok), .busy(busy), .rd_sel(rd_sel),
    .reset_pulse(reset_pulse), .autosel_pulse(autosel_pulse), .prog_pulse(prog_pulse),
    .prog_addr(prog_addr), .prog_data(prog_data), .erase_blk_pulse(erase_blk_pulse),
    .blk_idx(blk_idx), .erase_chip_pulse(erase_chip_pulse),
    .mwp_start_pulse(mwp_start_pulse), .autosel_mode(autosel_mode), .id_data(id_data)
  );

  function automatic logic [5:0] pulses();
    return {reset_pulse, autosel_pulse, prog_pulse, erase_blk_pulse,
            erase_chip_pulse, mwp_start_pulse};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one write; captures pulses and mode in the cycle after, then checks quiet
  task automatic do_wr(input logic [21:0] a, input logic [15:0] d,
                       input logic v, input logic b);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; vpp_ok = v; busy = b;
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
    got_p = pulses();
    got_m = autosel_mode;
    @(negedge clk);
    chk(pulses() == 6'b0, "R13", "pulse one cycle wide", 32'(pulses()), 32'h0);
  endtask

  // addr[45:24] data[23:8] vpp[7] pulses{rst,asel,prog,blk,chip,mwp}[6:1] mode[0]
  localparam int NV = 54;
  localparam logic [45:0] VECS [NV] = '{
    // R5 word program
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0055, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h00A0, 1'b1, 6'b000000, 1'b0},
    {22'h012345, 16'hBEEF, 1'b1, 6'b001000, 1'b0},
    // R6 block erase
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0055, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h0080, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0055, 1'b1, 6'b000000, 1'b0},
    {22'h3E1234, 16'h0030, 1'b1, 6'b000100, 1'b0},
    // R7 chip erase
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0055, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h0080, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0055, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h0010, 1'b1, 6'b000010, 1'b0},
    // R8 streamed program start
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0055, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h0020, 1'b1, 6'b000001, 1'b0},
    // R3 single and prefixed read/reset
    {22'h000123, 16'h00F0, 1'b0, 6'b100000, 1'b0},
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0055, 1'b1, 6'b000000, 1'b0},
    {22'h000777, 16'h00F0, 1'b1, 6'b100000, 1'b0},
    // R4 identification mode, persists, exits on F0
    {22'h000555, 16'h00AA, 1'b0, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0055, 1'b0, 6'b000000, 1'b0},
    {22'h000555, 16'h0090, 1'b0, 6'b010000, 1'b1},
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b1},
    {22'h0002AA, 16'h0055, 1'b1, 6'b000000, 1'b1},
    {22'h000555, 16'h00A0, 1'b1, 6'b000000, 1'b1},
    {22'h000000, 16'h00F0, 1'b1, 6'b100000, 1'b0},
    // R9 broken unlock falls back
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0066, 1'b1, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0055, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h00A0, 1'b1, 6'b000000, 1'b0},
    {22'h012345, 16'h1234, 1'b1, 6'b000000, 1'b0},
    // R2 upper bits ignored
    {22'h3FF555, 16'hFFAA, 1'b1, 6'b000000, 1'b0},
    {22'h2AAAAA, 16'hAB55, 1'b1, 6'b000000, 1'b0},
    {22'h1FF555, 16'h3320, 1'b1, 6'b000001, 1'b0},
    // R10 program and chip erase with voltage low at launch
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0055, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h00A0, 1'b1, 6'b000000, 1'b0},
    {22'h000010, 16'h1111, 1'b0, 6'b000000, 1'b0},
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0055, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h0080, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0055, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h0010, 1'b0, 6'b000000, 1'b0},
    // R3 read/reset in the middle of the erase prefix
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b0},
    {22'h0002AA, 16'h0055, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h0080, 1'b1, 6'b000000, 1'b0},
    {22'h000555, 16'h00AA, 1'b1, 6'b000000, 1'b0},
    {22'h000123, 16'h00F0, 1'b1, 6'b100000, 1'b0},
    {22'h000555, 16'h0010, 1'b1, 6'b000000, 1'b0}
  };

  initial begin
    #(8 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pulses() == 6'b0, "R1", "pulses after reset", 32'(pulses()), 32'h0);
    chk(autosel_mode == 1'b0, "R1", "mode after reset", 32'(autosel_mode), 32'h0);
    chk(id_data == 16'h0, "R1", "id after reset", 32'(id_data), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VECS[i];
      do_wr(v[45:24], v[23:8], v[7], 1'b0);
      chk(got_p == v[6:1], "R13", $sformatf("row %0d pulses", i), 32'(got_p), 32'(v[6:1]));
      chk(got_m == v[0], "R4", $sformatf("row %0d mode", i), 32'(got_m), 32'(v[0]));
      if (v[4]) begin
        // R5 launch address and data
        chk(prog_addr == v[45:24], "R5", "prog_addr", 32'(prog_addr), 32'(v[45:24]));
        chk(prog_data == v[23:8], "R5", "prog_data", 32'(prog_data), 32'(v[23:8]));
      end
      if (v[3]) begin
        // R6 block index from top address bits
        chk(blk_idx == v[45:41], "R6", "blk_idx", 32'(blk_idx), 32'(v[45:41]));
      end
    end

    // R5 data slot takes F0 as data
    do_wr(22'h000555, 16'h00AA, 1'b1, 1'b0);
    do_wr(22'h0002AA, 16'h0055, 1'b1, 1'b0);
    do_wr(22'h000555, 16'h00A0, 1'b1, 1'b0);
    do_wr(22'h0000F0, 16'h00F0, 1'b1, 1'b0);
    chk(got_p == 6'b001000, "R5", "F0 as program data", 32'(got_p), 32'h08);
    chk(prog_data == 16'h00F0, "R5", "prog_data F0", 32'(prog_data), 32'hF0);

    // R11 busy holds the sequence state and drops F0
    do_wr(22'h000555, 16'h00AA, 1'b1, 1'b0);
    do_wr(22'h0002AA, 16'h0055, 1'b1, 1'b0);
    do_wr(22'h000555, 16'h0090, 1'b1, 1'b1);
    chk(got_p == 6'b0 && got_m == 1'b0, "R11", "busy write ignored", 32'({got_p, got_m}), 32'h0);
    do_wr(22'h000000, 16'h00F0, 1'b1, 1'b1);
    chk(got_p == 6'b0, "R11", "busy F0 ignored", 32'(got_p), 32'h0);
    do_wr(22'h000555, 16'h0090, 1'b1, 1'b0);
    chk(got_p == 6'b010000 && got_m, "R11", "state held across busy", 32'({got_p, got_m}), 32'h21);
    do_wr(22'h000000, 16'h00F0, 1'b1, 1'b1);
    chk(autosel_mode == 1'b1, "R11", "busy F0 keeps mode", 32'(autosel_mode), 32'h1);

    // R12 identity reads
    @(negedge clk); rd_sel = 2'b00;
    @(negedge clk);
    chk(id_data == 16'h0020, "R12", "maker id", 32'(id_data), 32'h0020);
    rd_sel = 2'b01;
    @(negedge clk);
    chk(id_data == 16'h88AF, "R12", "device id", 32'(id_data), 32'h88AF);
    rd_sel = 2'b10;
    @(negedge clk);
    chk(id_data == 16'h0000, "R12", "unused select", 32'(id_data), 32'h0);
    rd_sel = 2'b01;
    do_wr(22'h3FF000, 16'hFFF0, 1'b0, 1'b0);
    chk(got_p == 6'b100000 && !got_m, "R4", "F0 exits mode", 32'({got_p, got_m}), 32'h40);
    chk(id_data == 16'h0000, "R12", "id outside mode", 32'(id_data), 32'h0);

    // R13 no pulse without a write
    repeat (3) @(negedge clk);
    chk(pulses() == 6'b0, "R13", "idle quiet", 32'(pulses()), 32'h0);

    // R1 reset from mid-sequence clears state
    do_wr(22'h000555, 16'h00AA, 1'b1, 1'b0);
    do_wr(22'h0002AA, 16'h0055, 1'b1, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_wr(22'h000555, 16'h0020, 1'b1, 1'b0);
    chk(got_p == 6'b0, "R1", "reset discards prefix", 32'(got_p), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule